// File: doc/BRIEF.md
# Legacy INTx Message Generator

This block turns the level-sensitive interrupt lines of up to eight endpoint functions into legacy Assert_INTx and Deassert_INTx message requests. Each function's level is routed to one of the four virtual wires (A, B, C or D) by that function's Interrupt Pin register value. A function whose Command register Interrupt Disable bit is set is left out of the routing. The levels routed to the same wire are ORed together. Only a change of an ORed wire, rising or falling, produces a message.

Each wire keeps at most one pending event. If a wire changes back before its pending event has left the block, the two events cancel and neither is sent. Pending events go out one at a time through a valid/ready message port that carries the wire index and whether the message asserts or deasserts it. Every function's raw level is also sampled into a per-function status vector, which feeds the Interrupt Status bit of the PCI Status register. While the link is down or reset is active, every wire returns to deasserted and no message is offered. The interrupt inputs are expected to be synchronous to `clk`.

Top module: `intx_msg_gen`

## Requirements
- R1: `irq_status[i]` equals the value `func_irq[i]` had at the previous clock edge. This holds whatever the Interrupt Disable bit or the Interrupt Pin value of function i is.
- R2: Function i's 3-bit pin field `func_pin[3*i+2:3*i]` routes its level as follows: 1 goes to wire A (`msg_wire`=0), 2 to B (1), 3 to C (2) and 4 to D (3). The values 0, 5, 6 and 7 route it to no wire, so it never causes a message.
- R3: While `func_irq_dis[i]` is 1, function i is left out of the wire OR. Clearing or setting that bit while the level is high counts as a rising or falling edge of the wire.
- R4: A message is sent only when the OR of all routed, unmasked levels on a wire changes. A second function raising the same wire sends nothing, and the deassert follows only when the last of them drops.
- R5: A rising wire produces a message with `msg_assert`=1 and a falling wire one with `msg_assert`=0. With the message port idle, `msg_valid` rises two clock edges after the level change.
- R6: While `msg_valid` is 1 and `msg_ready` is 0 with the link up, `msg_valid`, `msg_wire` and `msg_assert` hold their values at the next edge.
- R7: An assert and a deassert that are both pending for the same wire, and not yet offered on the port, cancel each other, and neither is sent.
- R8: When several wires have pending events, the lowest wire index (A first) is offered first.
- R9: While `link_up` is 0 or reset is active, all wires are treated as deasserted, pending and offered events are dropped, and `msg_valid` is 0 after the next edge. When the link comes back, wires whose OR is high send an assert.
- R10: On each wire, the messages accepted alternate between assert and deassert, starting with assert after reset or link down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link active; 0 clears all wire state |
| func_irq | input | NUM_FUNC | Level interrupt per function |
| func_pin | input | 3*NUM_FUNC | Interrupt Pin value per function |
| func_irq_dis | input | NUM_FUNC | Interrupt Disable command bit per function |
| irq_status | output | NUM_FUNC | Sampled raw level per function, to the PCI Status register |
| msg_valid | output | 1 | Message request offered |
| msg_ready | input | 1 | Message request accepted when high with msg_valid |
| msg_wire | output | 2 | Virtual wire: 0=A, 1=B, 2=C, 3=D |
| msg_assert | output | 1 | 1 = Assert_INTx, 0 = Deassert_INTx |

## Verification
The assertions check on every cycle that the status vector follows the raw levels, that an unaccepted message stays unchanged, and that a down link clears the port. They also check that each wire's accepted messages alternate between assert and deassert. Several behaviours can only be shown by the bench's scenarios: pin decoding, masking, the OR that hides a second function's edge, cancellation of a short pulse behind a stalled port, the priority order across wires, and the re-assert after the link returns. Each of these depends on a particular input sequence and on which messages come out.

// File: rtl/intx_msg_gen.sv
module intx_msg_gen #(
  parameter int NUM_FUNC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_up,
  input  logic [NUM_FUNC-1:0]   func_irq,
  input  logic [3*NUM_FUNC-1:0] func_pin,
  input  logic [NUM_FUNC-1:0]   func_irq_dis,
  output logic [NUM_FUNC-1:0]   irq_status,
  output logic                  msg_valid,
  input  logic                  msg_ready,
  output logic [1:0]            msg_wire,
  output logic                  msg_assert
);
  localparam int NW = 4;

  logic [NW-1:0] wire_or, wire_q, edge_w, pend_v, pend_k, take;
  logic [1:0]    sel;
  logic          any_pend, load_en;
  logic          out_valid, out_assert;
  logic [1:0]    out_wire;

  always_comb begin
    wire_or = '0;
    for (int f = 0; f < NUM_FUNC; f++)
      for (int w = 0; w < NW; w++)
        if (!func_irq_dis[f] && func_pin[3*f +: 3] == 3'(w + 1))
          wire_or[w] = wire_or[w] | func_irq[f];
  end

  assign edge_w = wire_or ^ wire_q;

  always_comb begin
    any_pend = 1'b0;
    sel = '0;
    for (int w = NW - 1; w >= 0; w--)
      if (pend_v[w]) begin
        any_pend = 1'b1;
        sel = 2'(w);
      end
  end

  assign load_en = !out_valid || msg_ready;
  assign take    = (any_pend && load_en) ? (NW'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_status <= '0;
    else        irq_status <= func_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wire_q <= '0;
      pend_v <= '0;
      pend_k <= '0;
    end else if (!link_up) begin
      wire_q <= '0;
      pend_v <= '0;
      pend_k <= '0;
    end else begin
      wire_q <= wire_or;
      for (int w = 0; w < NW; w++) begin
        if (edge_w[w]) begin
          if (pend_v[w] && !take[w]) pend_v[w] <= 1'b0;
          else begin
            pend_v[w] <= 1'b1;
            pend_k[w] <= wire_or[w];
          end
        end else if (take[w]) begin
          pend_v[w] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wire   <= '0;
      out_assert <= 1'b0;
    end else if (!link_up) begin
      out_valid  <= 1'b0;
    end else if (load_en) begin
      out_valid <= any_pend;
      if (any_pend) begin
        out_wire   <= sel;
        out_assert <= pend_k[sel];
      end
    end
  end

  assign msg_valid  = out_valid;
  assign msg_wire   = out_wire;
  assign msg_assert = out_assert;

  logic [NW-1:0] told_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        told_q <= '0;
    else if (!link_up)                 told_q <= '0;
    else if (msg_valid && msg_ready)   told_q[msg_wire] <= msg_assert;
  end

  // R1
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_status == $past(func_irq));

  // R6
  hold_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && link_up) |=>
      (msg_valid && $stable(msg_wire) && $stable(msg_assert)));

  // R9
  link_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> !msg_valid);

  // R10
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_assert != told_q[msg_wire]);
endmodule

// File: tb/tb_intx_msg_gen.sv
module tb_intx_msg_gen;
  localparam int NF = 8;
  logic clk = 0, rst_n = 0, link_up = 0, msg_ready = 0;
  logic [NF-1:0] func_irq = '0, func_irq_dis = '0, irq_status;
  logic [3*NF-1:0] func_pin = '0;
  logic msg_valid, msg_assert;
  logic [1:0] msg_wire;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  intx_msg_gen #(.NUM_FUNC(NF)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .func_irq(func_irq),
    .func_pin(func_pin), .func_irq_dis(func_irq_dis), .irq_status(irq_status),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_wire(msg_wire),
    .msg_assert(msg_assert));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int f, input logic [2:0] v);
    func_pin[3*f +: 3] = v;
  endtask

  task automatic take(input int w, input bit a, input string req);
    chk(msg_valid === 1'b1, req, int'(msg_valid), 1);
    chk(msg_wire == 2'(w) && msg_assert == a, req,
        int'(msg_wire) * 10 + int'(msg_assert), w * 10 + int'(a));
    msg_ready = 1;
    cyc(1);
    msg_ready = 0;
  endtask

  task automatic none(input string req);
    chk(msg_valid === 1'b0, req, int'(msg_valid), 0);
  endtask

  task automatic t_reset;
    chk(msg_valid === 1'b0 && irq_status === '0, "R9 reset", int'(msg_valid), 0);
    rst_n = 1; link_up = 1;
    cyc(2);
  endtask

  task automatic t_route;
    set_pin(0, 3'd1); set_pin(1, 3'd4); set_pin(2, 3'd0); set_pin(3, 3'd6);
    func_irq[0] = 1; cyc(2); take(0, 1, "R2 R5 pin1 A assert");
    func_irq[0] = 0; cyc(2); take(0, 0, "R5 A deassert");
    func_irq[1] = 1; cyc(2); take(3, 1, "R2 pin4 D assert");
    func_irq[1] = 0; cyc(2); take(3, 0, "R2 D deassert");
    func_irq[2] = 1; func_irq[3] = 1; cyc(1);
    chk(irq_status[3:2] == 2'b11, "R1 status unrouted", int'(irq_status[3:2]), 3);
    cyc(3); none("R2 pin 0/6 silent");
    func_irq[2] = 0; func_irq[3] = 0; cyc(3); none("R2 pin 0/6 silent low");
  endtask

  task automatic t_mask;
    set_pin(4, 3'd2); func_irq_dis[4] = 1;
    func_irq[4] = 1; cyc(1);
    chk(irq_status[4] == 1'b1, "R1 status masked", int'(irq_status[4]), 1);
    cyc(3); none("R3 masked silent");
    func_irq_dis[4] = 0; cyc(2); take(1, 1, "R3 unmask asserts B");
    func_irq_dis[4] = 1; cyc(2); take(1, 0, "R3 mask deasserts B");
    func_irq[4] = 0; func_irq_dis[4] = 0; cyc(3); none("R3 quiet");
  endtask

  task automatic t_or;
    set_pin(5, 3'd3); set_pin(6, 3'd3);
    func_irq[5] = 1; cyc(2); take(2, 1, "R4 first C assert");
    func_irq[6] = 1; cyc(3); none("R4 second source silent");
    func_irq[5] = 0; cyc(3); none("R4 one remaining silent");
    func_irq[6] = 0; cyc(2); take(2, 0, "R4 last drop deasserts");
  endtask

  task automatic t_hold;
    func_irq[0] = 1; cyc(2);
    for (int i = 0; i < 5; i++) begin
      chk(msg_valid && msg_wire == 2'd0 && msg_assert, "R6 held", int'(msg_valid), 1);
      cyc(1);
    end
    take(0, 1, "R6 accepted");
    func_irq[0] = 0; cyc(2); take(0, 0, "R6 deassert");
  endtask

  task automatic t_cancel;
    func_irq[1] = 1; cyc(2);
    func_irq[0] = 1; cyc(1); func_irq[0] = 0; cyc(3);
    take(3, 1, "R7 stalled D");
    cyc(2); none("R7 pulse cancelled");
    func_irq[1] = 0; cyc(2); take(3, 0, "R7 D deassert");
  endtask

  task automatic t_prio;
    func_irq[1] = 1; func_irq[5] = 1; func_irq[0] = 1; cyc(3);
    take(0, 1, "R8 A first");
    take(2, 1, "R8 C second");
    take(3, 1, "R8 D third");
    none("R8 drained");
    func_irq[0] = 0; func_irq[1] = 0; func_irq[5] = 0; cyc(3);
    take(0, 0, "R8 A off"); take(2, 0, "R8 C off"); take(3, 0, "R8 D off");
  endtask

  task automatic t_link;
    func_irq[0] = 1; cyc(2); take(0, 1, "R9 A up");
    link_up = 0; cyc(1); func_irq[0] = 0; cyc(3); none("R9 down silent");
    func_irq[0] = 1; cyc(2); link_up = 1; cyc(2);
    take(0, 1, "R9 R10 reassert after link");
    func_irq[1] = 1; cyc(2);
    chk(msg_valid === 1'b1, "R9 pending before drop", int'(msg_valid), 1);
    link_up = 0; cyc(1); none("R9 offered dropped");
    link_up = 1; cyc(3);
    take(0, 1, "R9 A again"); take(3, 1, "R9 D again");
    func_irq[0] = 0; func_irq[1] = 0; cyc(3);
    take(0, 0, "R10 A off"); take(3, 0, "R10 D off");
  endtask

  initial begin
    cyc(3);
    t_reset(); t_route(); t_mask(); t_or(); t_hold();
    t_cancel(); t_prio(); t_link();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule